// File: doc/BRIEF.md
# TLB Fault Dropin Handle

This block is the per-control-block handle through which a TLB miss is handed to software and a translation is handed back. When the execution side reports a miss, the handle latches the faulting virtual address, its ASID, the index/way, context number and color, records a cause code, and parks in one of two miss states. The miss state depends on whether the request runs in user polling mode or is reported through the fault map.

Software reads the handle through a small word-addressed register port. It writes the fill fields: the fill ASID, the fill virtual address, a 41-bit page frame number, the dirty bit, a 2-bit address attribute and a page-size code. It then issues an opcode by writing word 0 with the start bit set. Depending on the opcode, the handle writes a small fully associative TLB model, releases the stalled request, signals an exception, or switches the miss to polling mode. A lookup port on the TLB model exposes the stored translations. The frame number is always scaled by 4 KB, whatever the page size.

Top module: `tlb_dropin_handle`

## Requirements
- R1: After reset the state field reads 0 (inactive), status reads 0 (idle), cause reads 0, and every TLB lookup misses.
- R2: A miss with cause 1 (tlb-miss) or 2 (tlb-modify), offered while the state is inactive, idle or hw-error, is captured. Word 1 then holds the virtual address and word 2 bits 23:0 hold the ASID. In word 0, bits 51:40 hold the index/way, 55:52 the context, bit 19 the color and 38:32 the cause. The state (word 0 bits 22:20) becomes 2 (miss, user polling) when miss_upoll_i is set and 3 (miss, fault map) otherwise, and status (bits 17:16) becomes 0.
- R3: A miss with cause 3, 4, 5, 6 or 8 moves the state to 4 (hw-error) with status 1 (exception) and records the cause. Miss causes 0, 7 and 9 to 15 are ignored.
- R4: A miss offered while a miss or an operation is outstanding is ignored, and the recorded miss fields stay unchanged.
- R5: Opcode 2 (write only), issued by writing word 0 with bit 0 set and the opcode in bits 6:4, gives state 5 (write-tlb) with status 2 (active) for one cycle. In that cycle tlb_we_o is high. The state then returns to the miss state it came from, with status 0 and no restart.
- R6: Opcode 3 (write and restart) gives one write-tlb cycle, then one cycle in state 6 (restart) with restart_o high, then state 1 (idle) with status 0.
- R7: Opcode 1 (restart) gives one cycle in state 6 with restart_o high, then state 1. The TLB is not written.
- R8: Opcode 4 (exception) raises except_o for the cycle after the command and moves the state to 1 with status 0.
- R9: Opcode 7 (user polling) moves state 3 to state 2 with status 0. Opcode 0 in a miss state changes nothing but sets status 0.
- R10: Any opcode, noop included, issued while the state is not 2 or 3 sets status to 1 and leaves the state alone. A busy operation hit this way still completes, but it leaves status at 1.
- R11: Opcodes 5 and 6 in a miss state set status to 1 and leave the state unchanged.
- R12: A TLB lookup hits when the ASID equals the fill ASID and the virtual address agrees above the page shift. Page codes 0 to 8 give shifts of 12, 14, 16, 18, 20, 21, 22, 24 and 26, and larger codes give a shift of 26. The physical address is (PFN << 12) plus the address offset within the page, and the dirty bit and address attribute (0 RAM, 1 MMIO, 2 uncached RAM, 3 register) are returned. Each fill goes to slot index/way mod ENTRIES, where it replaces the previous entry. During the write cycle tlb_wr_paddr_o equals PFN << 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss report strobe |
| miss_cause_i | input | 4 | Cause code of the report |
| miss_upoll_i | input | 1 | Request runs in user polling mode |
| miss_vaddr_i | input | 64 | Faulting virtual address |
| miss_asid_i | input | 24 | Faulting ASID |
| miss_idxway_i | input | 12 | TLB index/way of the miss |
| miss_ctx_i | input | 4 | Context number |
| miss_color_i | input | 1 | Color bit |
| miss_ready_o | output | 1 | Handle can take a new report |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register write word |
| reg_wdata_i | input | 64 | Register write data |
| reg_raddr_i | input | 3 | Register read word |
| reg_rdata_o | output | 64 | Register read data |
| tlb_we_o | output | 1 | TLB write strobe |
| tlb_wr_slot_o | output | SLOT_W | Slot being written |
| tlb_wr_paddr_o | output | 53 | Physical base being written |
| restart_o | output | 1 | Resume the stalled request |
| except_o | output | 1 | Fail the stalled request |
| lk_vaddr_i | input | 64 | Lookup virtual address |
| lk_asid_i | input | 24 | Lookup ASID |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 53 | Translated physical address |
| lk_dirty_o | output | 1 | Dirty bit of the hit |
| lk_gaa_o | output | 2 | Address attribute of the hit |

## Verification
The bench builds the handle with ENTRIES set to 4. As a result, index/way 5 lands on slot 1 and a later fill through the same miss overwrites the first translation, which makes slot replacement visible at the lookup port. Page codes 0, 2 and 9 cover the smallest shift, a middle shift and the clamp to 26 bits. Two back-to-back commands drive a command into the write-tlb cycle, which exercises the busy path.

// File: rtl/tdh_pkg.sv
package tdh_pkg;
  localparam int VA_W    = 64;
  localparam int ASID_W  = 24;
  localparam int PFN_W   = 41;
  localparam int PA_W    = PFN_W + 12;
  localparam int IDX_W   = 12;
  localparam int CTX_W   = 4;
  localparam int CAUSE_W = 7;
  localparam int PGSZ_W  = 5;

  typedef enum logic [2:0] {
    ST_INACTIVE = 3'd0,
    ST_IDLE     = 3'd1,
    ST_MISS_UP  = 3'd2,
    ST_MISS_FM  = 3'd3,
    ST_HW_ERR   = 3'd4,
    ST_WR_TLB   = 3'd5,
    ST_RESTART  = 3'd6
  } st_e;

  localparam logic [1:0] SS_IDLE   = 2'd0;
  localparam logic [1:0] SS_EXC    = 2'd1;
  localparam logic [1:0] SS_ACTIVE = 2'd2;

  localparam logic [2:0] OP_NOOP   = 3'd0;
  localparam logic [2:0] OP_RST    = 3'd1;
  localparam logic [2:0] OP_WR     = 3'd2;
  localparam logic [2:0] OP_WR_RST = 3'd3;
  localparam logic [2:0] OP_EXC    = 3'd4;
  localparam logic [2:0] OP_UPOLL  = 3'd7;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   vaddr;
    logic [PFN_W-1:0]  pfn;
    logic              dirty;
    logic [1:0]        gaa;
    logic [PGSZ_W-1:0] pgsz;
  } fill_t;

  function automatic logic [4:0] pg_shift(input logic [PGSZ_W-1:0] code);
    case (code)
      5'd0: pg_shift = 5'd12;
      5'd1: pg_shift = 5'd14;
      5'd2: pg_shift = 5'd16;
      5'd3: pg_shift = 5'd18;
      5'd4: pg_shift = 5'd20;
      5'd5: pg_shift = 5'd21;
      5'd6: pg_shift = 5'd22;
      5'd7: pg_shift = 5'd24;
      default: pg_shift = 5'd26;
    endcase
  endfunction
endpackage

// File: rtl/tdh_regs.sv
module tdh_regs
  import tdh_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         waddr_i,
  input  logic [63:0]        wdata_i,
  input  logic [2:0]         raddr_i,
  output logic [63:0]        rdata_o,
  input  st_e                state_i,
  input  logic [1:0]         status_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               color_i,
  input  logic [IDX_W-1:0]   idxway_i,
  input  logic [CTX_W-1:0]   ctx_i,
  input  logic [VA_W-1:0]    mvaddr_i,
  input  logic [ASID_W-1:0]  masid_i,
  output logic               cmd_o,
  output logic [2:0]         opc_o,
  output fill_t              fill_o
);
  logic [2:0] opc_q;
  fill_t      fill_q;

  assign cmd_o  = we_i && (waddr_i == 3'd0) && wdata_i[0];
  assign opc_o  = wdata_i[6:4];
  assign fill_o = fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q  <= OP_NOOP;
      fill_q <= '0;
    end else if (we_i) begin
      case (waddr_i)
        3'd0: opc_q <= wdata_i[6:4];
        3'd2: begin
          fill_q.asid  <= wdata_i[55:32];
          fill_q.dirty <= wdata_i[56];
          fill_q.gaa   <= wdata_i[58:57];
        end
        3'd3: begin
          fill_q.pfn  <= wdata_i[40:0];
          fill_q.pgsz <= wdata_i[52:48];
        end
        3'd4: fill_q.vaddr <= wdata_i;
        default: ;
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[63:59], wdata_i[31:7], wdata_i[3:1], wdata_i[47:41]};

  always_comb begin
    case (raddr_i)
      3'd0: rdata_o = {8'b0, ctx_i, idxway_i, 1'b0, cause_i, 9'b0, state_i,
                       color_i, 1'b0, status_i, 9'b0, opc_q, 4'b0};
      3'd1: rdata_o = mvaddr_i;
      3'd2: rdata_o = {5'b0, fill_q.gaa, fill_q.dirty, fill_q.asid, 8'b0, masid_i};
      3'd3: rdata_o = {11'b0, fill_q.pgsz, 7'b0, fill_q.pfn};
      3'd4: rdata_o = fill_q.vaddr;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tdh_ctrl.sv
module tdh_ctrl
  import tdh_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [3:0]         miss_cause_i,
  input  logic               miss_upoll_i,
  input  logic [VA_W-1:0]    miss_vaddr_i,
  input  logic [ASID_W-1:0]  miss_asid_i,
  input  logic [IDX_W-1:0]   miss_idxway_i,
  input  logic [CTX_W-1:0]   miss_ctx_i,
  input  logic               miss_color_i,
  output logic               miss_ready_o,
  input  logic               cmd_i,
  input  logic [2:0]         opc_i,
  output st_e                state_o,
  output logic [1:0]         status_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               color_o,
  output logic [IDX_W-1:0]   idxway_o,
  output logic [CTX_W-1:0]   ctx_o,
  output logic [VA_W-1:0]    mvaddr_o,
  output logic [ASID_W-1:0]  masid_o,
  output logic               tlb_we_o,
  output logic               restart_o,
  output logic               except_o
);
  st_e                st_q, ret_q;
  logic [1:0]         ss_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               color_q, pend_q, exc_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CTX_W-1:0]   ctx_q;
  logic [VA_W-1:0]    va_q;
  logic [ASID_W-1:0]  asid_q;

  logic in_miss, c_miss, c_hw, take;
  assign in_miss      = (st_q == ST_MISS_UP) || (st_q == ST_MISS_FM);
  assign miss_ready_o = (st_q == ST_INACTIVE) || (st_q == ST_IDLE) || (st_q == ST_HW_ERR);
  assign c_miss       = (miss_cause_i == 4'd1) || (miss_cause_i == 4'd2);
  assign c_hw         = ((miss_cause_i >= 4'd3) && (miss_cause_i <= 4'd6)) || (miss_cause_i == 4'd8);
  assign take         = miss_valid_i && miss_ready_o && (c_miss || c_hw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INACTIVE;
      ret_q   <= ST_MISS_FM;
      ss_q    <= SS_IDLE;
      cause_q <= '0;
      color_q <= 1'b0;
      pend_q  <= 1'b0;
      exc_q   <= 1'b0;
      idx_q   <= '0;
      ctx_q   <= '0;
      va_q    <= '0;
      asid_q  <= '0;
    end else begin
      exc_q <= 1'b0;
      // busy progression; an exception raised while busy is kept
      if (st_q == ST_WR_TLB) begin
        st_q <= pend_q ? ST_RESTART : ret_q;
        if (!pend_q && ss_q != SS_EXC) ss_q <= SS_IDLE;
      end else if (st_q == ST_RESTART) begin
        st_q <= ST_IDLE;
        if (ss_q != SS_EXC) ss_q <= SS_IDLE;
      end
      if (take) begin
        va_q    <= miss_vaddr_i;
        asid_q  <= miss_asid_i;
        idx_q   <= miss_idxway_i;
        ctx_q   <= miss_ctx_i;
        color_q <= miss_color_i;
        cause_q <= {3'b0, miss_cause_i};
        st_q    <= c_hw ? ST_HW_ERR : (miss_upoll_i ? ST_MISS_UP : ST_MISS_FM);
        ss_q    <= c_hw ? SS_EXC : SS_IDLE;
      end
      if (cmd_i) begin
        if (!in_miss) begin
          ss_q <= SS_EXC;
        end else begin
          case (opc_i)
            OP_NOOP:  ss_q <= SS_IDLE;
            OP_RST: begin
              st_q <= ST_RESTART;
              ss_q <= SS_ACTIVE;
            end
            OP_WR, OP_WR_RST: begin
              st_q   <= ST_WR_TLB;
              ret_q  <= st_q;
              pend_q <= (opc_i == OP_WR_RST);
              ss_q   <= SS_ACTIVE;
            end
            OP_EXC: begin
              st_q  <= ST_IDLE;
              ss_q  <= SS_IDLE;
              exc_q <= 1'b1;
            end
            OP_UPOLL: begin
              st_q <= ST_MISS_UP;
              ss_q <= SS_IDLE;
            end
            default: ss_q <= SS_EXC;
          endcase
        end
      end
    end
  end

  assign state_o   = st_q;
  assign status_o  = ss_q;
  assign cause_o   = cause_q;
  assign color_o   = color_q;
  assign idxway_o  = idx_q;
  assign ctx_o     = ctx_q;
  assign mvaddr_o  = va_q;
  assign masid_o   = asid_q;
  assign tlb_we_o  = (st_q == ST_WR_TLB);
  assign restart_o = (st_q == ST_RESTART);
  assign except_o  = exc_q;
endmodule

// File: rtl/tdh_tlb.sv
module tdh_tlb
  import tdh_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  fill_t             fill_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic              lk_dirty_o,
  output logic [1:0]        lk_gaa_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VA_W-1:0]    va_q   [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [4:0]         sh_q   [ENTRIES];
  logic               dty_q  [ENTRIES];
  logic [1:0]         gaa_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        asid_q[e] <= '0;
        va_q[e]   <= '0;
        pfn_q[e]  <= '0;
        sh_q[e]   <= 5'd12;
        dty_q[e]  <= 1'b0;
        gaa_q[e]  <= '0;
      end else if (we_i && (slot_i == SLOT_W'(e))) begin
        vld_q[e]  <= 1'b1;
        asid_q[e] <= fill_i.asid;
        va_q[e]   <= fill_i.vaddr;
        pfn_q[e]  <= fill_i.pfn;
        sh_q[e]   <= pg_shift(fill_i.pgsz);
        dty_q[e]  <= fill_i.dirty;
        gaa_q[e]  <= fill_i.gaa;
      end
    end
    assign match[e] = vld_q[e] && (asid_q[e] == lk_asid_i) &&
                      (((va_q[e] ^ lk_vaddr_i) >> sh_q[e]) == '0);
  end

  always_comb begin
    lk_hit_o   = 1'b0;
    lk_paddr_o = '0;
    lk_dirty_o = 1'b0;
    lk_gaa_o   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        lk_hit_o   = 1'b1;
        lk_paddr_o = {pfn_q[e], 12'b0} +
                     PA_W'(lk_vaddr_i & ((64'd1 << sh_q[e]) - 64'd1));
        lk_dirty_o = dty_q[e];
        lk_gaa_o   = gaa_q[e];
      end
    end
  end
endmodule

// File: rtl/tlb_dropin_handle.sv
module tlb_dropin_handle
  import tdh_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [3:0]        miss_cause_i,
  input  logic              miss_upoll_i,
  input  logic [63:0]       miss_vaddr_i,
  input  logic [23:0]       miss_asid_i,
  input  logic [11:0]       miss_idxway_i,
  input  logic [3:0]        miss_ctx_i,
  input  logic              miss_color_i,
  output logic              miss_ready_o,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  input  logic [2:0]        reg_raddr_i,
  output logic [63:0]       reg_rdata_o,
  output logic              tlb_we_o,
  output logic [SLOT_W-1:0] tlb_wr_slot_o,
  output logic [52:0]       tlb_wr_paddr_o,
  output logic              restart_o,
  output logic              except_o,
  input  logic [63:0]       lk_vaddr_i,
  input  logic [23:0]       lk_asid_i,
  output logic              lk_hit_o,
  output logic [52:0]       lk_paddr_o,
  output logic              lk_dirty_o,
  output logic [1:0]        lk_gaa_o
);
  st_e                st;
  logic [1:0]         status;
  logic [CAUSE_W-1:0] cause;
  logic               color, cmd;
  logic [2:0]         opc;
  logic [IDX_W-1:0]   idxway;
  logic [CTX_W-1:0]   ctx;
  logic [VA_W-1:0]    mvaddr;
  logic [ASID_W-1:0]  masid;
  fill_t              fill;

  tdh_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .miss_valid_i, .miss_cause_i, .miss_upoll_i, .miss_vaddr_i, .miss_asid_i,
    .miss_idxway_i, .miss_ctx_i, .miss_color_i, .miss_ready_o,
    .cmd_i(cmd), .opc_i(opc),
    .state_o(st), .status_o(status), .cause_o(cause), .color_o(color),
    .idxway_o(idxway), .ctx_o(ctx), .mvaddr_o(mvaddr), .masid_o(masid),
    .tlb_we_o, .restart_o, .except_o
  );

  tdh_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .raddr_i(reg_raddr_i), .rdata_o(reg_rdata_o),
    .state_i(st), .status_i(status), .cause_i(cause), .color_i(color),
    .idxway_i(idxway), .ctx_i(ctx), .mvaddr_i(mvaddr), .masid_i(masid),
    .cmd_o(cmd), .opc_o(opc), .fill_o(fill)
  );

  assign tlb_wr_slot_o  = SLOT_W'(idxway);
  assign tlb_wr_paddr_o = {fill.pfn, 12'b0};

  tdh_tlb #(.ENTRIES(ENTRIES)) u_tlb (
    .clk_i, .rst_ni,
    .we_i(tlb_we_o), .slot_i(tlb_wr_slot_o), .fill_i(fill),
    .lk_vaddr_i, .lk_asid_i, .lk_hit_o, .lk_paddr_o, .lk_dirty_o, .lk_gaa_o
  );
endmodule

module tdh_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] st_i,
  input logic [1:0] status_i,
  input logic       cmd_i,
  input logic       miss_valid_i,
  input logic [3:0] miss_cause_i,
  input logic       restart_i,
  input logic       except_i,
  input logic       tlb_we_i
);
  logic st_miss, st_ready;
  assign st_miss  = (st_i == 3'd2) || (st_i == 3'd3);
  assign st_ready = (st_i == 3'd0) || (st_i == 3'd1) || (st_i == 3'd4);

  a_r2_miss_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i && st_ready && !cmd_i && (miss_cause_i == 4'd1 || miss_cause_i == 4'd2)
    |=> (st_i == 3'd2 || st_i == 3'd3));
  a_r5_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_i |=> !tlb_we_i);
  a_r6_restart_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (st_i == 3'd1));
  a_r8_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({restart_i, except_i, tlb_we_i}));
  a_r10_cmd_outside_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i && !st_miss && !miss_valid_i |=> (status_i == 2'd1));
  a_r11_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i != 2'd3);
endmodule

bind tlb_dropin_handle tdh_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .status_i(status), .cmd_i(cmd),
  .miss_valid_i(miss_valid_i), .miss_cause_i(miss_cause_i),
  .restart_i(restart_o), .except_i(except_o), .tlb_we_i(tlb_we_o)
);

// File: tb/tlb_dropin_handle_bench.sv
module tlb_dropin_handle_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 4;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, miss_upoll = 0, miss_color = 0, miss_ready;
  logic [3:0]  miss_cause = 0, miss_ctx = 0;
  logic [63:0] miss_vaddr = 0, reg_wdata = 0, reg_rdata, lk_vaddr = 0;
  logic [23:0] miss_asid = 0, lk_asid = 0;
  logic [11:0] miss_idx = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0, reg_raddr = 0;
  logic        tlb_we, restart, except_s, lk_hit, lk_dirty;
  logic [1:0]  tlb_slot, lk_gaa;
  logic [52:0] tlb_wr_paddr, lk_paddr;

  int n_vec = 0, n_bad = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_dropin_handle #(.ENTRIES(ENT)) u_tlb_dropin_handle (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_cause_i(miss_cause), .miss_upoll_i(miss_upoll),
    .miss_vaddr_i(miss_vaddr), .miss_asid_i(miss_asid), .miss_idxway_i(miss_idx),
    .miss_ctx_i(miss_ctx), .miss_color_i(miss_color), .miss_ready_o(miss_ready),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .tlb_we_o(tlb_we), .tlb_wr_slot_o(tlb_slot), .tlb_wr_paddr_o(tlb_wr_paddr),
    .restart_o(restart), .except_o(except_s),
    .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid), .lk_hit_o(lk_hit),
    .lk_paddr_o(lk_paddr), .lk_dirty_o(lk_dirty), .lk_gaa_o(lk_gaa)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: 1=tlb write, 2=restart, 3=exception
  always @(negedge clk) begin
    if (rst_n && (tlb_we || restart || except_s)) begin
      int code;
      code = (32'(tlb_we) + 32'(restart) + 32'(except_s) > 1) ? 9 :
             tlb_we ? 1 : restart ? 2 : 3;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected event got=%0d exp=none", code);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != code) begin
          n_bad++;
          $display("FAIL R6 event got=%0d exp=%0d", code, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic cmd(input logic [2:0] op);
    wr(3'd0, {57'b0, op, 4'b0001});
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic w0(output logic [2:0] st, output logic [1:0] ss, output logic [6:0] cs);
    logic [63:0] d;
    rd(3'd0, d);
    st = d[22:20]; ss = d[17:16]; cs = d[38:32];
  endtask

  task automatic miss(input logic [3:0] c, input logic up, input logic [63:0] va,
                      input logic [23:0] as, input logic [11:0] ix);
    miss_valid = 1; miss_cause = c; miss_upoll = up; miss_vaddr = va;
    miss_asid = as; miss_idx = ix; miss_ctx = 4'd3; miss_color = 1;
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic fill(input logic [23:0] as, input logic dty, input logic [1:0] g,
                      input logic [40:0] pfn, input logic [4:0] pz, input logic [63:0] va);
    wr(3'd2, {5'b0, g, dty, as, 32'b0});
    wr(3'd3, {11'b0, pz, 7'b0, pfn});
    wr(3'd4, va);
  endtask

  task automatic look(input logic [63:0] va, input logic [23:0] as);
    lk_vaddr = va; lk_asid = as; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] st; logic [1:0] ss; logic [6:0] cs; logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    w0(st, ss, cs);
    check("R1 state", st, 0); check("R1 status", ss, 0); check("R1 cause", cs, 0);
    look(64'h1000, 24'h0); check("R1 lookup", lk_hit, 0);

    // R10 opcode while inactive
    cmd(3'd0);
    w0(st, ss, cs);
    check("R10 status", ss, 1); check("R10 state", st, 0);

    // R2 miss capture
    miss(4'd1, 0, 64'h0000_1234_5678_9ABC, 24'h00ABCD, 12'd5);
    rd(3'd0, d);
    check("R2 state", d[22:20], 3); check("R2 status", d[17:16], 0);
    check("R2 cause", d[38:32], 1); check("R2 idxway", d[51:40], 5);
    check("R2 ctx", d[55:52], 3); check("R2 color", d[19], 1);
    rd(3'd1, d); check("R2 vaddr", d, 64'h0000_1234_5678_9ABC);
    rd(3'd2, d); check("R2 asid", d[23:0], 24'h00ABCD);

    // R4 second miss ignored
    miss(4'd2, 1, 64'hDEAD_0000, 24'h7, 12'd9);
    rd(3'd1, d); check("R4 vaddr kept", d, 64'h0000_1234_5678_9ABC);
    rd(3'd0, d); check("R4 idxway kept", d[51:40], 5);

    // R5 write only
    fill(24'h00ABCD, 1, 2'd2, 41'h12345, 5'd0, 64'h0000_1234_5678_9ABC);
    exp_q.push_back(1);
    cmd(3'd2);
    w0(st, ss, cs);
    check("R5 wr state", st, 5); check("R5 wr status", ss, 2);
    check("R12 wr paddr", tlb_wr_paddr, 53'h12345000);
    check("R12 wr slot", tlb_slot, 1);
    @(negedge clk);
    w0(st, ss, cs);
    check("R5 back state", st, 3); check("R5 back status", ss, 0);
    look(64'h0000_1234_5678_9ABC, 24'h00ABCD);
    check("R12 hit", lk_hit, 1); check("R12 paddr", lk_paddr, 53'h12345ABC);
    check("R12 dirty", lk_dirty, 1); check("R12 gaa", lk_gaa, 2);
    look(64'h0000_1234_5678_9ABC, 24'h00ABCE); check("R12 asid miss", lk_hit, 0);
    look(64'h0000_1234_5678_AABC, 24'h00ABCD); check("R12 page miss", lk_hit, 0);

    // R9 user polling
    cmd(3'd7);
    w0(st, ss, cs);
    check("R9 state", st, 2); check("R9 status", ss, 0);
    cmd(3'd0);
    w0(st, ss, cs);
    check("R9 noop state", st, 2); check("R9 noop status", ss, 0);

    // R11 undefined opcode
    cmd(3'd5);
    w0(st, ss, cs);
    check("R11 status", ss, 1); check("R11 state", st, 2);

    // R6 write and restart, page code 2
    fill(24'h000011, 0, 2'd1, 41'h400, 5'd2, 64'h0007_0000);
    exp_q.push_back(1); exp_q.push_back(2);
    cmd(3'd3);
    w0(st, ss, cs);
    check("R6 wr state", st, 5); check("R6 wr status", ss, 2);
    @(negedge clk);
    w0(st, ss, cs);
    check("R6 rst state", st, 6); check("R6 restart pulse", restart, 1);
    @(negedge clk);
    w0(st, ss, cs);
    check("R6 idle", st, 1); check("R6 status", ss, 0);
    look(64'h0007_1234, 24'h11);
    check("R12 code2 hit", lk_hit, 1); check("R12 code2 paddr", lk_paddr, 53'h401234);
    check("R12 code2 gaa", lk_gaa, 1);
    look(64'h0008_0000, 24'h11); check("R12 code2 outside", lk_hit, 0);
    look(64'h0000_1234_5678_9ABC, 24'h00ABCD); check("R12 slot replaced", lk_hit, 0);

    // R10 opcode while idle
    cmd(3'd1);
    w0(st, ss, cs);
    check("R10 idle status", ss, 1); check("R10 idle state", st, 1);

    // R3 hardware error and ignored causes
    miss(4'd4, 0, 64'hBEEF, 24'h2, 12'd2);
    w0(st, ss, cs);
    check("R3 state", st, 4); check("R3 status", ss, 1); check("R3 cause", cs, 4);
    miss(4'd9, 0, 64'hCAFE, 24'h2, 12'd2);
    w0(st, ss, cs); check("R3 ignored state", st, 4);
    rd(3'd1, d); check("R3 ignored vaddr", d, 64'hBEEF);
    miss(4'd7, 0, 64'hCAFE, 24'h2, 12'd2);
    rd(3'd1, d); check("R3 cause7 ignored", d, 64'hBEEF);

    // R7 restart from polling miss
    miss(4'd2, 1, 64'h5000, 24'h2, 12'd2);
    w0(st, ss, cs);
    check("R2 upoll state", st, 2); check("R2 modify cause", cs, 2);
    exp_q.push_back(2);
    cmd(3'd1);
    w0(st, ss, cs);
    check("R7 state", st, 6); check("R7 status", ss, 2);
    @(negedge clk);
    w0(st, ss, cs);
    check("R7 idle", st, 1);
    look(64'h0007_1234, 24'h11); check("R7 tlb untouched", lk_hit, 1);

    // R8 exception opcode
    miss(4'd1, 0, 64'h6000, 24'h2, 12'd2);
    exp_q.push_back(3);
    cmd(3'd4);
    check("R8 pulse", except_s, 1);
    w0(st, ss, cs);
    check("R8 state", st, 1); check("R8 status", ss, 0);

    // R10 busy command, page code clamp
    miss(4'd1, 0, 64'h7000, 24'h2, 12'd2);
    fill(24'h000033, 0, 2'd3, 41'h8000, 5'd9, 64'h0C00_0000);
    exp_q.push_back(1);
    cmd(3'd2);
    cmd(3'd0);
    w0(st, ss, cs);
    check("R10 busy state", st, 3); check("R10 busy status", ss, 1);
    look(64'h0FFF_FFF0, 24'h33);
    check("R12 clamp hit", lk_hit, 1); check("R12 clamp paddr", lk_paddr, 53'hBFFFFF0);
    check("R12 clamp gaa", lk_gaa, 3);

    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", 64'(exp_q.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule